// File: doc/BRIEF.md
# GPIO Task Action Executor

This block holds the output latches of a bank of general-purpose pins and lets a small set of hardware task channels update them. Each task channel carries three one-cycle strobes: drive high, drive low and invert. Any pin may be attached to one task channel through a per-pin configuration byte. When the strobe arrives, every pin attached to that channel and enabled takes the matching action on the next clock edge. One channel may drive many pins, and each pin listens to a single channel.

The configuration lives in a small word-addressed register file. Each 32-bit word packs four pins, one byte lane per pin. The lane bit 0 enables the pin for task control, and lane bits 3:1 name its task channel. Software can also write pin levels directly through a per-pin write mask. Pad multiplexing and the routing of events to task strobes are handled outside this block.

Top module: `gpio_task_exec`

## Requirements
- R1: After reset every pin output is 0 and every configuration word reads back as 0.
- R2: Pin n is configured in word n/4, byte lane n%4. Lane bit 0 is the enable and lane bits 3:1 are the task channel number. A full-word write takes effect at the next clock edge, and the word reads back combinationally at `cfg_addr`.
- R3: Lane bits 7:4 always read 0 and ignore writes. The whole lane of a pin index at or above the pin count (lane 3 of word 7 by default) also reads 0 and ignores writes.
- R4: A set strobe on channel c drives every enabled pin attached to c to 1 at the next clock edge.
- R5: A clear strobe on channel c drives every enabled pin attached to c to 0 at the next clock edge.
- R6: A toggle strobe on channel c inverts every enabled pin attached to c at the next clock edge. A pin starting low ends low after 10 toggles, and ends high after 5 more.
- R7: All pins attached to the same channel respond in the same cycle to one strobe on that channel.
- R8: A pin with its enable bit at 0 ignores all strobes. An enabled pin ignores strobes on channels other than its own.
- R9: When clear and set arrive together on one channel, clear takes effect. Toggle takes effect only when neither set nor clear is asserted on that channel.
- R10: A software level write (`sw_we[n]`=1) loads `sw_level[n]` at the next edge if the pin has no task action in that cycle. A task action in the same cycle overrides the software write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration word |
| cfg_addr | input | 3 | Configuration word index for read and write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data at `cfg_addr` |
| task_set | input | 8 | Per-channel drive-high strobes |
| task_clr | input | 8 | Per-channel drive-low strobes |
| task_tog | input | 8 | Per-channel invert strobes |
| sw_we | input | 31 | Per-pin software level write mask |
| sw_level | input | 31 | Software level values |
| gpio_level | output | 31 | Pin output latches |

## Verification
The bench goes after lane placement: a design that mis-decodes n/4 or n%4 would move a pin's enable or channel to a neighbour's byte, so readback and strobe response would land on the wrong pin. It sweeps every channel against many pin-to-channel maps and strobe mixes. These sweeps catch a pin that answers a foreign channel, a disabled pin that still moves, and a fan-out that reaches only part of its pins. Simultaneous set and clear would expose a wrong priority as a high output. A software write racing a task action would show the software value where the task value belongs. Writes of all ones to every word would show nonzero reserved bits or a phantom 32nd pin if the masking were wrong.

// File: rtl/gte_pkg.sv
package gte_pkg;

  localparam int LANES    = 4;
  localparam int LANE_W   = 8;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } act_e;

  // Priority: clear over set, toggle only when neither is present.
  function automatic act_e resolve_act(logic s, logic c, logic t);
    if (c)      return ACT_CLR;
    else if (s) return ACT_SET;
    else if (t) return ACT_TOG;
    else        return ACT_NONE;
  endfunction

  // Next latch value: task action first, software write second, else hold.
  function automatic logic next_level(act_e a, logic q, logic we, logic lv);
    case (a)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TOG: return ~q;
      default: return we ? lv : q;
    endcase
  endfunction

  // Bits of word `word_idx` that carry real configuration state.
  function automatic logic [31:0] live_mask(int word_idx, int num_gpio, int ch_w);
    logic [31:0] m;
    m = '0;
    for (int l = 0; l < LANES; l++) begin
      if (word_idx * LANES + l < num_gpio) begin
        for (int b = 0; b <= ch_w; b++) m[l*LANE_W + b] = 1'b1;
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/gte_cfg_regs.sv
module gte_cfg_regs
  import gte_pkg::*;
#(
  parameter int NUM_GPIO = 31,
  parameter int CH_W     = 3,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_GPIO-1:0]            pin_en,
  output logic [NUM_GPIO-1:0][CH_W-1:0]  pin_sel
);

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
    localparam int WORD = g / LANES;
    localparam int LSB  = (g % LANES) * LANE_W;
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(WORD));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_en[g]  <= 1'b0;
        pin_sel[g] <= '0;
      end else if (hit) begin
        pin_en[g]  <= wdata[LSB];
        pin_sel[g] <= wdata[LSB+1 +: CH_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NUM_GPIO; g++) begin
      if (addr == ADDR_W'(g / LANES)) begin
        rdata[(g % LANES) * LANE_W]              = pin_en[g];
        rdata[(g % LANES) * LANE_W + 1 +: CH_W]  = pin_sel[g];
      end
    end
  end

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~live_mask(int'(addr), NUM_GPIO, CH_W)) == '0);

  p_lane0_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> (pin_en[0] == $past(wdata[0])) &&
                              (pin_sel[0] == $past(wdata[CH_W:1])));

endmodule

// File: rtl/gte_act_decode.sv
module gte_act_decode
  import gte_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  input  logic [NUM_CH-1:0] tog_i,
  output act_e [NUM_CH-1:0] act_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign act_o[c] = resolve_act(set_i[c], clr_i[c], tog_i[c]);
  end

endmodule

// File: rtl/gte_out_latch.sv
module gte_out_latch
  import gte_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  input  logic sw_we,
  input  logic sw_lv,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= next_level(act, q, sw_we, sw_lv);
  end

  p_set_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_SET |=> q);
  p_clr_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_CLR |=> !q);
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act == ACT_TOG |=> q != $past(q));
  p_sw_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_NONE && sw_we) |=> q == $past(sw_lv));

endmodule

// File: rtl/gpio_task_exec.sv
module gpio_task_exec
  import gte_pkg::*;
#(
  parameter int NUM_GPIO = 31,
  parameter int NUM_CH   = 8,
  parameter int DATA_W   = 32,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int NUM_REG = (NUM_GPIO + LANES - 1) / LANES,
  localparam int ADDR_W  = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr_en,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic [NUM_CH-1:0]   task_set,
  input  logic [NUM_CH-1:0]   task_clr,
  input  logic [NUM_CH-1:0]   task_tog,
  input  logic [NUM_GPIO-1:0] sw_we,
  input  logic [NUM_GPIO-1:0] sw_level,
  output logic [NUM_GPIO-1:0] gpio_level
);

  logic [NUM_GPIO-1:0]           pin_en;
  logic [NUM_GPIO-1:0][CH_W-1:0] pin_sel;
  act_e [NUM_CH-1:0]             ch_act;
  act_e [NUM_GPIO-1:0]           pin_act;

  gte_cfg_regs #(
    .NUM_GPIO (NUM_GPIO),
    .CH_W     (CH_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .pin_en  (pin_en),
    .pin_sel (pin_sel)
  );

  gte_act_decode #(.NUM_CH(NUM_CH)) i_dec (
    .set_i (task_set),
    .clr_i (task_clr),
    .tog_i (task_tog),
    .act_o (ch_act)
  );

  for (genvar g = 0; g < NUM_GPIO; g++) begin : g_out
    assign pin_act[g] = pin_en[g] ? ch_act[pin_sel[g]] : ACT_NONE;

    gte_out_latch i_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (pin_act[g]),
      .sw_we (sw_we[g]),
      .sw_lv (sw_level[g]),
      .q     (gpio_level[g])
    );

    p_disabled_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_en[g] && !sw_we[g]) |=> $stable(gpio_level[g]));

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en[g] && task_clr[pin_sel[g]]) |=> !gpio_level[g]);
  end

endmodule

// File: tb/test_gpio_task_exec.sv
module test_gpio_task_exec;

  localparam int NG = 31;
  localparam int NC = 8;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic [NC-1:0] task_set = '0, task_clr = '0, task_tog = '0;
  logic [NG-1:0] sw_we = '0, sw_level = '0;
  logic [NG-1:0] gpio_level;

  int tests = 0;
  int fails = 0;
  logic [31:0] lcg = 32'h1234_5678;

  logic          m_en  [NG];
  logic [2:0]    m_sel [NG];
  logic [NG-1:0] m_lvl;

  always #10 clk = ~clk;

  gpio_task_exec i_gpio_task_exec (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .task_set(task_set),
    .task_clr(task_clr), .task_tog(task_tog), .sw_we(sw_we),
    .sw_level(sw_level), .gpio_level(gpio_level)
  );

  function automatic logic [31:0] rnd(inout logic [31:0] s);
    s = s * 32'd1103515245 + 32'd12345;
    return s;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(int r);
    logic [31:0] w = '0;
    for (int l = 0; l < 4; l++) begin
      int n = r * 4 + l;
      if (n < NG) begin
        w[l*8]       = m_en[n];
        w[l*8+1 +: 3] = m_sel[n];
      end
    end
    return w;
  endfunction

  task automatic write_word(int r, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = 3'(r); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    for (int l = 0; l < 4; l++) begin
      int n = r * 4 + l;
      if (n < NG) begin
        m_en[n]  = d[l*8];
        m_sel[n] = d[l*8+1 +: 3];
      end
    end
  endtask

  task automatic read_check(string tag, int r);
    cfg_addr = 3'(r); #1;
    check(tag, cfg_rdata, model_word(r));
  endtask

  task automatic config_pin(int n, logic en, int ch);
    m_en[n] = en; m_sel[n] = 3'(ch);
    write_word(n / 4, model_word(n / 4));
  endtask

  task automatic step(string tag, logic [NC-1:0] s, logic [NC-1:0] c,
                      logic [NC-1:0] t, logic [NG-1:0] we, logic [NG-1:0] lv);
    @(negedge clk);
    task_set = s; task_clr = c; task_tog = t; sw_we = we; sw_level = lv;
    for (int n = 0; n < NG; n++) begin
      logic hit = 1'b0;
      if (m_en[n]) begin
        int ch = int'(m_sel[n]);
        hit = 1'b1;
        if (c[ch])      m_lvl[n] = 1'b0;
        else if (s[ch]) m_lvl[n] = 1'b1;
        else if (t[ch]) m_lvl[n] = ~m_lvl[n];
        else            hit = 1'b0;
      end
      if (!hit && we[n]) m_lvl[n] = lv[n];
    end
    @(posedge clk); #1;
    task_set = '0; task_clr = '0; task_tog = '0; sw_we = '0;
    check(tag, 32'(gpio_level), 32'(m_lvl));
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < NG; n++) begin m_en[n] = 1'b0; m_sel[n] = '0; end
    m_lvl = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    check("R1 outputs", 32'(gpio_level), 32'h0);
    for (int r = 0; r < NR; r++) read_check("R1 cfg", r);

    // R2 / R3: readback of patterns, reserved bits and phantom lane
    for (int r = 0; r < NR; r++) begin
      write_word(r, 32'hFFFF_FFFF);
      read_check("R3 all-ones", r);
      check("R3 masked", cfg_rdata, (r == NR-1) ? 32'h000F_0F0F : 32'h0F0F_0F0F);
    end
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < NR; r++) begin
        write_word(r, rnd(lcg));
        read_check("R2 pattern", r);
      end
    for (int r = 0; r < NR; r++) write_word(r, 32'h0);
    // R2 single pin lane placement: pin 13 -> word 3 lane 1
    config_pin(13, 1'b1, 5);
    cfg_addr = 3'd3; #1;
    check("R2 lane place", cfg_rdata, 32'h0000_0B00);
    config_pin(13, 1'b0, 0);

    // R6: 10 toggles then 5 toggles on one pin
    config_pin(1, 1'b1, 2);
    for (int i = 0; i < 10; i++) step("R6 toggle", '0, '0, 8'h04, '0, '0);
    check("R6 after 10", 32'(gpio_level[1]), 32'h0);
    for (int i = 0; i < 5; i++) step("R6 toggle", '0, '0, 8'h04, '0, '0);
    check("R6 after 15", 32'(gpio_level[1]), 32'h1);

    // R4 / R5 / R7: fan-out of channel 6 to several pins
    config_pin(0, 1'b1, 6); config_pin(7, 1'b1, 6); config_pin(30, 1'b1, 6);
    step("R7 set fanout", 8'h40, '0, '0, '0, '0);
    check("R4 set", {29'h0, gpio_level[30], gpio_level[7], gpio_level[0]}, 32'h7);
    step("R5 clear fanout", '0, 8'h40, '0, '0, '0);
    check("R5 clear", {29'h0, gpio_level[30], gpio_level[7], gpio_level[0]}, 32'h0);

    // R8: disabled pin ignores its channel; others ignore foreign channel
    config_pin(7, 1'b0, 6);
    step("R8 disabled", 8'h40, '0, '0, '0, '0);
    check("R8 disabled pin", 32'(gpio_level[7]), 32'h0);
    step("R8 foreign", 8'hBF, '0, '0, '0, '0);
    check("R8 foreign ch", 32'(gpio_level[0]), 32'h1);

    // R9: clear beats set; toggle masked by set
    step("R9 clr+set", 8'h40, 8'h40, '0, '0, '0);
    check("R9 clear wins", 32'(gpio_level[0]), 32'h0);
    step("R9 set+tog", 8'h40, '0, 8'h40, '0, '0);
    check("R9 tog masked", 32'(gpio_level[0]), 32'h1);

    // R10: software write alone and racing a task action
    step("R10 sw write", '0, '0, '0, NG'(1) << 5, NG'(1) << 5);
    check("R10 sw level", 32'(gpio_level[5]), 32'h1);
    step("R10 race", '0, 8'h40, '0, NG'(1), NG'(1));
    check("R10 task wins", 32'(gpio_level[0]), 32'h0);

    // Sweep: many random maps, random strobe mixes (R4 R5 R6 R7 R8 R9 R10)
    for (int map = 0; map < 40; map++) begin
      for (int r = 0; r < NR; r++) write_word(r, rnd(lcg) & rnd(lcg) | 32'h0101_0101);
      for (int c = 0; c < NC; c++) begin
        step("R4 sweep set", 8'(1 << c), '0, '0, '0, '0);
        step("R5 sweep clr", '0, 8'(1 << c), '0, '0, '0);
        step("R6 sweep tog", '0, '0, 8'(1 << c), '0, '0);
      end
      for (int i = 0; i < 20; i++)
        step("R9 R10 mixed", 8'(rnd(lcg)), 8'(rnd(lcg) & rnd(lcg)), 8'(rnd(lcg)),
             NG'(rnd(lcg)), NG'(rnd(lcg)));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule